// File: doc/BRIEF.md
# Power-Up Reset Sequencer with Cause Flags

This block generates the internal reset of a small microcontroller core. When the power-on detector lets go, the block runs a chain of delays before it releases the core. First comes an optional power-up delay. After that comes an optional oscillator settling delay, which applies only when a crystal oscillator mode is selected. A brown-out trip starts the same chain again. The external active-low clear pin, a watchdog expiry and a pending delay each hold the core in reset, but the pin does not start the delays itself. If the pin is held low past the end of the delays, the chain finishes in the background and the core starts as soon as the pin rises.

The block also holds a two-bit cause register that software reads and writes. Bit 1 records power loss and bit 0 records a brown-out. Software writes ones to both bits after start-up. A later reading of 0 in either bit then tells software which event caused the last reset. Delay lengths, the depth of the pin synchronizer and the presence of brown-out handling are parameters.

Top module: `pwrup_reset_seq`

## Requirements
- R1: While `por_active` is high, `core_rst` is 1. It goes to 1 at once, without waiting for a clock edge.
- R2: `osc_sel` is 0 for an external clock, 1 for the internal oscillator, 2 for the low-power crystal and 3 for the high-speed crystal. With `osc_sel` at 0 or 1 and `pwrt_en` at 0, `core_rst` falls right after the first clock edge that samples `por_active` low.
- R3: With `pwrt_en` at 1, the power-up delay adds exactly `PWRT_CYCLES` clock edges to the release.
- R4: With `osc_sel` at 2 or 3, the oscillator delay adds exactly `OST_CYCLES` edges. This delay starts only after the power-up delay has finished, when that delay is enabled. Modes 0 and 1 skip it.
- R5: The delays count from the end of the power-on or brown-out event, whatever `mclr_n` does. If `mclr_n` is still low when they finish, `core_rst` stays 1. Once `mclr_n` rises, `core_rst` falls after `MCLR_SYNC`+1 edges.
- R6: When `mclr_n` goes low while the core is running, `core_rst` is asserted. When the pin rises again, release takes `MCLR_SYNC`+1 edges and the delays do not run again.
- R7: Each cycle in which `wdt_expire` is sampled high asserts `core_rst` for the following cycle only. No delay is started.
- R8: A power-on event clears both cause flags to 0. Only the clearing of bit 1 is guaranteed to software.
- R9: With `BOD_ENABLE`=1, a `bod_trip` clears flag bit 0, leaves bit 1 alone and restarts the delay chain. With `BOD_ENABLE`=0, `bod_trip` has no effect.
- R10: A write (`flag_wr`=1) loads `flag_wdata` into both flags at the next edge. If a brown-out trip falls in the same cycle, bit 0 takes the cleared value.
- R11: A watchdog or pin reset leaves both cause flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_active | input | 1 | Power-on detector output, active high, asynchronous |
| bod_trip | input | 1 | Brown-out detector output, active high, synchronous |
| wdt_expire | input | 1 | Watchdog expiry, active high |
| mclr_n | input | 1 | External clear pin, active low, asynchronous |
| osc_sel | input | 2 | Oscillator mode: 0 external, 1 internal, 2/3 crystal |
| pwrt_en | input | 1 | Enables the power-up delay |
| flag_wr | input | 1 | Write strobe for the cause flags |
| flag_wdata | input | 2 | Data written to the cause flags |
| core_rst | output | 1 | Internal reset to the core, active high |
| cause_flags | output | 2 | Bit 1: power-on flag, bit 0: brown-out flag |

## Verification
Two functions can land on the same clock edge: the software write to the cause flags and the brown-out capture. The bench writes ones while `bod_trip` is high in the same cycle. It expects bit 0 to read 0 and bit 1 to read 1. A second write of 01, also during a trip, must give 00. A second overlap comes from holding `mclr_n` low through a full crystal start-up. In that case the bench counts the release edges only from the moment the pin rises, and compares that count with `MCLR_SYNC`+1.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

   typedef enum logic [1:0] {
      OSC_EXT   = 2'd0,
      OSC_INT   = 2'd1,
      OSC_XT_LO = 2'd2,
      OSC_XT_HI = 2'd3
   } osc_mode_t;

   typedef enum logic [1:0] {
      SQ_HOLD = 2'd0,
      SQ_PWRT = 2'd1,
      SQ_OST  = 2'd2,
      SQ_RUN  = 2'd3
   } seq_state_t;

   localparam int FLAG_W   = 2;
   localparam int FLAG_BOR = 0;
   localparam int FLAG_POR = 1;

   function automatic logic needs_settle(input osc_mode_t m);
      return (m == OSC_XT_LO) || (m == OSC_XT_HI);
   endfunction

endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
   parameter int STAGES    = 2,
   parameter bit RST_VALUE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("pwrup_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) sr <= {STAGES{RST_VALUE}};
            else if (STAGES == 1) sr[0] <= d;
            else sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pwrup_stage_timer.sv
module pwrup_stage_timer #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic done
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad
         $error("pwrup_stage_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign done = run && (cnt == LAST);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       cnt <= '0;
      else if (!run) cnt <= '0;
      else if (done) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   assert_count_in_range_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST)
      else $error("stage timer count beyond limit");

   assert_idle_count_zero_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(run) |-> (cnt == '0))
      else $error("stage timer not cleared while idle");
endmodule

// File: rtl/pwrup_cause_reg.sv
module pwrup_cause_reg
   import pwrup_pkg::*;
(
   input  logic              clk,
   input  logic              por,
   input  logic              bod_hit,
   input  logic              wr_en,
   input  logic [FLAG_W-1:0] wr_data,
   output logic [FLAG_W-1:0] flags
);
   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         flags <= '0;
      end else begin
         if (wr_en)   flags <= wr_data;
         if (bod_hit) flags[FLAG_BOR] <= 1'b0;
      end
   end

   assert_bod_clears_flag_R9: assert property (@(posedge clk) disable iff (por)
      bod_hit |=> !flags[FLAG_BOR])
      else $error("brown-out did not clear its flag");

   assert_por_flag_only_by_write_R11: assert property (@(posedge clk) disable iff (por)
      !wr_en |=> $stable(flags[FLAG_POR]))
      else $error("power-on flag changed without a write");

   assert_write_loads_R10: assert property (@(posedge clk) disable iff (por)
      wr_en |=> (flags[FLAG_POR] == $past(wr_data[FLAG_POR])))
      else $error("write did not load power-on flag");
endmodule

// File: rtl/pwrup_reset_seq.sv
module pwrup_reset_seq
   import pwrup_pkg::*;
#(
   parameter int PWRT_CYCLES = 65536,
   parameter int OST_CYCLES  = 1024,
   parameter int MCLR_SYNC   = 2,
   parameter bit BOD_ENABLE  = 1'b1
) (
   input  logic       clk,
   input  logic       por_active,
   input  logic       bod_trip,
   input  logic       wdt_expire,
   input  logic       mclr_n,
   input  logic [1:0] osc_sel,
   input  logic       pwrt_en,
   input  logic       flag_wr,
   input  logic [1:0] flag_wdata,
   output logic       core_rst,
   output logic [1:0] cause_flags
);
   generate
      if (PWRT_CYCLES < 1 || OST_CYCLES < 1) begin : g_bad_len
         $error("pwrup_reset_seq: delay lengths must be at least 1");
      end
      if (MCLR_SYNC > 4) begin : g_bad_sync
         $error("pwrup_reset_seq: MCLR_SYNC above 4 is not supported");
      end
   endgenerate

   logic bod_hit;
   generate
      if (BOD_ENABLE) begin : g_bod
         assign bod_hit = bod_trip;
      end else begin : g_no_bod
         assign bod_hit = 1'b0;
      end
   endgenerate

   logic mclr_ok;
   pwrup_sync #(.STAGES(MCLR_SYNC), .RST_VALUE(1'b1)) u_mclr_sync (
      .clk (clk),
      .rst (por_active),
      .d   (mclr_n),
      .q   (mclr_ok)
   );

   seq_state_t st, st_n;
   logic       settle;
   logic       pwrt_done, ost_done;

   assign settle = needs_settle(osc_mode_t'(osc_sel));

   pwrup_stage_timer #(.LIMIT(PWRT_CYCLES)) u_pwrt (
      .clk  (clk),
      .rst  (por_active),
      .run  (st == SQ_PWRT),
      .done (pwrt_done)
   );

   pwrup_stage_timer #(.LIMIT(OST_CYCLES)) u_ost (
      .clk  (clk),
      .rst  (por_active),
      .run  (st == SQ_OST),
      .done (ost_done)
   );

   always_comb begin
      st_n = st;
      unique case (st)
         SQ_HOLD: st_n = pwrt_en ? SQ_PWRT : (settle ? SQ_OST : SQ_RUN);
         SQ_PWRT: if (pwrt_done) st_n = settle ? SQ_OST : SQ_RUN;
         SQ_OST:  if (ost_done)  st_n = SQ_RUN;
         default: st_n = SQ_RUN;
      endcase
      if (bod_hit) st_n = SQ_HOLD;
   end

   always_ff @(posedge clk or posedge por_active) begin
      if (por_active) begin
         st       <= SQ_HOLD;
         core_rst <= 1'b1;
      end else begin
         st       <= st_n;
         core_rst <= (st_n != SQ_RUN) || !mclr_ok || wdt_expire;
      end
   end

   pwrup_cause_reg u_flags (
      .clk     (clk),
      .por     (por_active),
      .bod_hit (bod_hit),
      .wr_en   (flag_wr),
      .wr_data (flag_wdata),
      .flags   (cause_flags)
   );

   always_ff @(posedge clk) begin
      if (por_active) begin
         assert_por_holds_reset_R1: assert (core_rst)
            else $error("reset low during power-on");
      end
   end

   assert_wdt_pulse_R7: assert property (@(posedge clk) disable iff (por_active)
      wdt_expire |=> core_rst)
      else $error("watchdog did not assert reset");

   assert_release_needs_run_R2: assert property (@(posedge clk) disable iff (por_active)
      !core_rst |-> (st == SQ_RUN))
      else $error("reset released before delays finished");

   assert_settle_follows_pwrt_R4: assert property (@(posedge clk) disable iff (por_active)
      (st == SQ_OST && $past(st) != SQ_OST) |-> ($past(st) == SQ_PWRT || $past(st) == SQ_HOLD))
      else $error("oscillator delay entered out of order");

   assert_pin_no_restart_R6: assert property (@(posedge clk) disable iff (por_active)
      ($past(st) == SQ_RUN && !bod_hit && !$past(bod_hit)) |-> (st == SQ_RUN))
      else $error("delay chain restarted without power event");
endmodule

// File: tb/sim_pwrup_reset_seq.sv
module sim_pwrup_reset_seq;
   localparam int P = 20;
   localparam int O = 12;
   localparam int N = 2;

   logic       clk = 1'b0;
   logic       por_active = 1'b0;
   logic       bod_trip = 1'b0;
   logic       wdt_expire = 1'b0;
   logic       mclr_n = 1'b1;
   logic [1:0] osc_sel = 2'd0;
   logic       pwrt_en = 1'b0;
   logic       flag_wr = 1'b0;
   logic [1:0] flag_wdata = 2'd0;
   logic       core_rst;
   logic [1:0] cause_flags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pwrup_reset_seq #(.PWRT_CYCLES(P), .OST_CYCLES(O), .MCLR_SYNC(N), .BOD_ENABLE(1'b1)) u0 (
      .clk(clk), .por_active(por_active), .bod_trip(bod_trip), .wdt_expire(wdt_expire),
      .mclr_n(mclr_n), .osc_sel(osc_sel), .pwrt_en(pwrt_en), .flag_wr(flag_wr),
      .flag_wdata(flag_wdata), .core_rst(core_rst), .cause_flags(cause_flags)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // edges counted from the first edge after the release; returns edge index after which core_rst is 0
   task automatic edges_to_release(output int n);
      n = 0;
      for (int i = 1; i <= 200; i++) begin
         @(posedge clk); @(negedge clk);
         if (!core_rst) begin n = i; break; end
      end
   endtask

   task automatic power_cycle(input logic [1:0] mode, input logic pen);
      @(negedge clk);
      osc_sel = mode; pwrt_en = pen;
      por_active = 1'b1;
      #3;
      check("R1 reset during power-on", int'(core_rst), 1);
      @(negedge clk); @(negedge clk);
      check("R8 power flag cleared", int'(cause_flags[1]), 0);
      por_active = 1'b0;
   endtask

   task automatic write_flags(input logic [1:0] v, input logic bod);
      @(negedge clk);
      flag_wr = 1'b1; flag_wdata = v; bod_trip = bod;
      @(negedge clk);
      flag_wr = 1'b0; bod_trip = 1'b0;
   endtask

   initial begin
      int n;
      int exp;
      #1 por_active = 1'b1;
      #2;
      check("R1 reset at start", int'(core_rst), 1);
      check("R8 flags at start", int'(cause_flags), 0);

      // R2 R3 R4: sweep every oscillator mode with and without the power-up delay
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 2; p++) begin
            power_cycle(2'(m), 1'(p));
            edges_to_release(n);
            exp = 1 + (p != 0 ? P : 0) + (m >= 2 ? O : 0);
            if (p == 0 && m < 2) check("R2 immediate release", n, exp);
            else if (m < 2)      check("R3 power-up delay", n, exp);
            else                 check("R4 settle delay chain", n, exp);
         end
      end

      // R10 software write sets both flags
      write_flags(2'b11, 1'b0);
      check("R10 write flags", int'(cause_flags), 3);

      // R7 watchdog: one cycle of reset, flags kept (R11)
      @(negedge clk); wdt_expire = 1'b1;
      @(negedge clk); wdt_expire = 1'b0;
      check("R7 watchdog reset asserted", int'(core_rst), 1);
      @(negedge clk);
      check("R7 watchdog reset one cycle", int'(core_rst), 0);
      check("R11 flags after watchdog", int'(cause_flags), 3);

      // R6 pin reset during run
      @(negedge clk); mclr_n = 1'b0;
      for (int i = 0; i < 5; i++) @(negedge clk);
      check("R6 pin holds reset", int'(core_rst), 1);
      mclr_n = 1'b1;
      edges_to_release(n);
      check("R6 pin release without delays", n, N + 1);
      check("R11 flags after pin reset", int'(cause_flags), 3);

      // R5 pin held low through a full crystal start-up
      @(negedge clk); mclr_n = 1'b0;
      power_cycle(2'd3, 1'b1);
      for (int i = 0; i < P + O + 10; i++) @(negedge clk);
      check("R5 pin keeps reset after delays", int'(core_rst), 1);
      mclr_n = 1'b1;
      edges_to_release(n);
      check("R5 prompt release after delays", n, N + 1);

      // R9 brown-out clears bit 0, keeps bit 1, reruns chain
      osc_sel = 2'd0; pwrt_en = 1'b1;
      write_flags(2'b11, 1'b0);
      @(negedge clk); bod_trip = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R9 reset during brown-out", int'(core_rst), 1);
      bod_trip = 1'b0;
      check("R9 brown-out flags", int'(cause_flags), 2);
      edges_to_release(n);
      check("R9 chain rerun after brown-out", n, P + 1);

      // R10 write colliding with brown-out
      write_flags(2'b11, 1'b1);
      check("R10 collision bit0 cleared", int'(cause_flags), 2);
      edges_to_release(n);
      write_flags(2'b01, 1'b1);
      check("R10 collision write 01", int'(cause_flags), 0);
      edges_to_release(n);
      check("R9 release after collision", int'(core_rst), 0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule